// File: doc/BRIEF.md
# Tri-state pulse encoder

This block turns a word of three-valued address symbols (zero, one, open), followed by a few plain binary data bits, into one serial line. Each symbol goes out as a pair of pulses. Each pulse is either long or short, and the long/short combination of the pair carries the third "open" state. The word closes with a quiet gap, and the next word follows at once. This repeats for as long as the block is enabled.

Timing is taken from a single-cycle `tick` strobe that comes from an external time base. The block changes state only on clocks where `tick` is high. The address and data inputs are captured once at the start of each word, so the surrounding logic can change them at any moment without tearing a word in flight. The counts are parameters. The default is 10 address symbols and 8 data bits. A configuration with 12 address symbols and no data bits is also supported.

Top module: `tsp_encoder`

## Requirements
- R1: Each pulse fills a slot of 4 ticks. A short pulse is high for 1 tick and then low for 3. A long pulse is high for 3 ticks and then low for 1.
- R2: An address symbol with code 2'b00 (zero) is sent as a long pulse followed by a long pulse.
- R3: An address symbol with code 2'b01 (one) is sent as a short pulse followed by a short pulse.
- R4: An address symbol with code 2'b10 (open) is sent as a long pulse followed by a short pulse. Code 2'b11 is sent the same way.
- R5: A data bit uses the same coding as an address symbol. A bit of 0 is sent as long then long, and a bit of 1 as short then short.
- R6: A word sends address symbol 0 first and then the address symbols in rising index order. Data bit 0 follows, then the data bits in rising index order. The line then stays low for 16 ticks. The next word starts on the following tick.
- R7: While `en` is low, `tx_out` is low from the next clock edge on, and ticks have no effect. When a tick arrives with `en` high, that tick starts a fresh word at its first pulse.
- R8: `addr_sym` and `data_bits` are captured on the tick that starts a word. Changes made while the word is in flight appear only in the next word.
- R9: The state advances only on clocks where `tick` is high. Between ticks, `tx_out` holds its value.
- R10: After a synchronous reset, `tx_out` is low and the block is idle.
- R11: With N_DATA = 0 and 12 address symbols, a word is 12 symbol pairs followed by the 16-tick gap, for a total of 112 ticks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | Time-base strobe; one tick per high cycle |
| en | input | 1 | Transmit enable |
| addr_sym | input | 2*N_ADDR | Address symbol codes, symbol i at bits [2i+1:2i] |
| data_bits | input | DATA_W | Data bits, bit j sent after the address symbols |
| tx_out | output | 1 | Serial pulse-coded line |

## Verification
The tick that starts a word, or that advances it, takes effect on the clock edge where `tick` is high. The new line level can be seen just after that edge, because `tx_out` is decoded from the sequencer registers without any further register stage. The bench drives each tick for exactly one clock and samples at the falling edge that follows. One clock later, with `tick` low, it samples again to confirm that the level held. A drop of `en` shows up as a low line one clock edge later. The bench keeps its own copy of the inputs, captured on the tick it knows starts a word, so mid-word changes are checked against the word they should land in.

// File: rtl/tsp_pkg.sv
package tsp_pkg;

    // Pulse timing in time-base ticks
    localparam int SLOT_TICKS_D = 4;
    localparam int SHORT_HI_D   = 1;
    localparam int LONG_HI_D    = 3;
    localparam int SYNC_TICKS_D = 16;

    typedef enum logic [1:0] {
        SYM_ZERO  = 2'b00,
        SYM_ONE   = 2'b01,
        SYM_OPEN  = 2'b10,
        SYM_OPEN2 = 2'b11
    } sym_code_e;

    typedef enum logic {
        PULSE_SHORT = 1'b0,
        PULSE_LONG  = 1'b1
    } pulse_kind_e;

    // Kind of pulse for a symbol code and the pulse index within its pair
    function automatic pulse_kind_e pulse_for(input logic [1:0] code, input logic second);
        case (sym_code_e'(code))
            SYM_ZERO: return PULSE_LONG;
            SYM_ONE:  return PULSE_SHORT;
            default:  return second ? PULSE_SHORT : PULSE_LONG;
        endcase
    endfunction

endpackage

// File: rtl/tsp_sequencer.sv
module tsp_sequencer #(
    parameter int NSYM       = 18,
    parameter int SLOT_TICKS = 4,
    parameter int SYNC_TICKS = 16,
    localparam int SYM_W     = (NSYM > 1) ? $clog2(NSYM) : 1,
    localparam int SUB_W     = (SLOT_TICKS > 1) ? $clog2(SLOT_TICKS) : 1,
    localparam int SYNC_W    = (SYNC_TICKS > 1) ? $clog2(SYNC_TICKS) : 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick,
    input  logic             en,
    output logic             active,
    output logic             in_sync,
    output logic [SYM_W-1:0] sym_idx,
    output logic             second,
    output logic [SUB_W-1:0] sub,
    output logic             word_start
);
    localparam logic [SYM_W-1:0]  LAST_SYM  = SYM_W'(NSYM - 1);
    localparam logic [SUB_W-1:0]  LAST_SUB  = SUB_W'(SLOT_TICKS - 1);
    localparam logic [SYNC_W-1:0] LAST_SYNC = SYNC_W'(SYNC_TICKS - 1);

    logic [SYNC_W-1:0] sync_cnt;

    assign word_start = en && tick && (!active || (in_sync && sync_cnt == LAST_SYNC));

    always_ff @(posedge clk) begin
        if (rst || !en) begin
            active   <= 1'b0;
            in_sync  <= 1'b0;
            sym_idx  <= '0;
            second   <= 1'b0;
            sub      <= '0;
            sync_cnt <= '0;
        end else if (tick) begin
            if (!active) begin
                active   <= 1'b1;
                in_sync  <= 1'b0;
                sym_idx  <= '0;
                second   <= 1'b0;
                sub      <= '0;
                sync_cnt <= '0;
            end else if (in_sync) begin
                if (sync_cnt == LAST_SYNC) begin
                    in_sync  <= 1'b0;
                    sync_cnt <= '0;
                end else begin
                    sync_cnt <= sync_cnt + 1'b1;
                end
            end else if (sub == LAST_SUB) begin
                sub <= '0;
                if (second) begin
                    second <= 1'b0;
                    if (sym_idx == LAST_SYM) begin
                        sym_idx <= '0;
                        in_sync <= 1'b1;
                    end else begin
                        sym_idx <= sym_idx + 1'b1;
                    end
                end else begin
                    second <= 1'b1;
                end
            end else begin
                sub <= sub + 1'b1;
            end
        end
    end

    // R6: symbol index never leaves the word
    p_sym_in_range_r6: assert property (@(posedge clk) disable iff (rst)
        active |-> (sym_idx <= LAST_SYM));

    // R6: gap ends only after its full length
    p_sync_length_r6: assert property (@(posedge clk) disable iff (rst)
        ($fell(in_sync) && $past(en)) |-> ($past(sync_cnt) == LAST_SYNC));

    // R9: no tick, no movement
    p_no_tick_hold_r9: assert property (@(posedge clk) disable iff (rst)
        (en && !tick) |=> ($stable(sub) && $stable(sym_idx) && $stable(second)));

endmodule

// File: rtl/tsp_frame_latch.sv
module tsp_frame_latch #(
    parameter int N_ADDR   = 10,
    parameter int N_DATA   = 8,
    parameter int DATA_W   = 8,
    localparam int NSYM    = N_ADDR + N_DATA
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  load,
    input  logic [2*N_ADDR-1:0]   addr_sym,
    input  logic [DATA_W-1:0]     data_bits,
    output logic [2*NSYM-1:0]     shadow
);
    logic [2*NSYM-1:0] word_codes;

    for (genvar i = 0; i < NSYM; i++) begin : g_sym
        if (i < N_ADDR) begin : g_addr
            assign word_codes[2*i +: 2] = addr_sym[2*i +: 2];
        end else begin : g_data
            // binary data bit mapped onto the zero/one codes
            assign word_codes[2*i +: 2] = {1'b0, data_bits[i - N_ADDR]};
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            shadow <= '0;
        end else if (load) begin
            shadow <= word_codes;
        end
    end

    // R8: captured word never changes mid-flight
    p_shadow_hold_r8: assert property (@(posedge clk) disable iff (rst)
        !load |=> $stable(shadow));

endmodule

// File: rtl/tsp_pulse_gen.sv
module tsp_pulse_gen
    import tsp_pkg::*;
#(
    parameter int NSYM       = 18,
    parameter int SLOT_TICKS = 4,
    parameter int SHORT_HI   = 1,
    parameter int LONG_HI    = 3,
    localparam int SYM_W     = (NSYM > 1) ? $clog2(NSYM) : 1,
    localparam int SUB_W     = (SLOT_TICKS > 1) ? $clog2(SLOT_TICKS) : 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [2*NSYM-1:0] shadow,
    input  logic              active,
    input  logic              in_sync,
    input  logic [SYM_W-1:0]  sym_idx,
    input  logic              second,
    input  logic [SUB_W-1:0]  sub,
    output logic              tx
);
    localparam logic [SUB_W:0] SHORT_L = (SUB_W+1)'(SHORT_HI);
    localparam logic [SUB_W:0] LONG_L  = (SUB_W+1)'(LONG_HI);

    logic [1:0]      code;
    pulse_kind_e     kind;
    logic [SUB_W:0]  hi_len;

    assign code   = shadow[{sym_idx, 1'b0} +: 2];
    assign kind   = pulse_for(code, second);
    assign hi_len = (kind == PULSE_LONG) ? LONG_L : SHORT_L;
    assign tx     = active && !in_sync && ({1'b0, sub} < hi_len);

    // R3: a one symbol is low after its first tick
    p_one_short_r3: assert property (@(posedge clk) disable iff (rst)
        (active && !in_sync && code == 2'b01 && sub == SUB_W'(SHORT_HI)) |-> !tx);

    // R4: the first pulse of an open symbol is still high in its last high tick
    p_open_first_long_r4: assert property (@(posedge clk) disable iff (rst)
        (active && !in_sync && code[1] && !second && sub == SUB_W'(LONG_HI - 1)) |-> tx);

    // R4: the second pulse of an open symbol is short
    p_open_second_short_r4: assert property (@(posedge clk) disable iff (rst)
        (active && !in_sync && code[1] && second && sub == SUB_W'(SHORT_HI)) |-> !tx);

endmodule

// File: rtl/tsp_encoder.sv
module tsp_encoder
    import tsp_pkg::*;
#(
    parameter int N_ADDR     = 10,
    parameter int N_DATA     = 8,
    parameter int DATA_W     = (N_DATA > 0) ? N_DATA : 1,
    parameter int SLOT_TICKS = SLOT_TICKS_D,
    parameter int SHORT_HI   = SHORT_HI_D,
    parameter int LONG_HI    = LONG_HI_D,
    parameter int SYNC_TICKS = SYNC_TICKS_D
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                tick,
    input  logic                en,
    input  logic [2*N_ADDR-1:0] addr_sym,
    input  logic [DATA_W-1:0]   data_bits,
    output logic                tx_out
);
    localparam int NSYM  = N_ADDR + N_DATA;
    localparam int SYM_W = (NSYM > 1) ? $clog2(NSYM) : 1;
    localparam int SUB_W = (SLOT_TICKS > 1) ? $clog2(SLOT_TICKS) : 1;

    logic              active;
    logic              in_sync;
    logic [SYM_W-1:0]  sym_idx;
    logic              second;
    logic [SUB_W-1:0]  sub;
    logic              word_start;
    logic [2*NSYM-1:0] shadow;

    tsp_sequencer #(
        .NSYM(NSYM), .SLOT_TICKS(SLOT_TICKS), .SYNC_TICKS(SYNC_TICKS)
    ) u_seq (
        .clk(clk), .rst(rst), .tick(tick), .en(en),
        .active(active), .in_sync(in_sync), .sym_idx(sym_idx),
        .second(second), .sub(sub), .word_start(word_start)
    );

    tsp_frame_latch #(
        .N_ADDR(N_ADDR), .N_DATA(N_DATA), .DATA_W(DATA_W)
    ) u_latch (
        .clk(clk), .rst(rst), .load(word_start),
        .addr_sym(addr_sym), .data_bits(data_bits), .shadow(shadow)
    );

    tsp_pulse_gen #(
        .NSYM(NSYM), .SLOT_TICKS(SLOT_TICKS), .SHORT_HI(SHORT_HI), .LONG_HI(LONG_HI)
    ) u_pulse (
        .clk(clk), .rst(rst), .shadow(shadow), .active(active), .in_sync(in_sync),
        .sym_idx(sym_idx), .second(second), .sub(sub), .tx(tx_out)
    );

    // R7: disabled line goes quiet at the next edge
    p_idle_low_r7: assert property (@(posedge clk) disable iff (rst)
        !en |=> !tx_out);

    // R1: every pulse slot opens high
    p_slot_opens_high_r1: assert property (@(posedge clk) disable iff (rst)
        (active && !in_sync && sub == '0) |-> tx_out);

    // R1: every pulse slot closes low
    p_slot_closes_low_r1: assert property (@(posedge clk) disable iff (rst)
        (sub == SUB_W'(SLOT_TICKS - 1)) |-> !tx_out);

    // R6: the gap is low
    p_gap_low_r6: assert property (@(posedge clk) disable iff (rst)
        in_sync |-> !tx_out);

    // R9: line holds between ticks
    p_line_hold_r9: assert property (@(posedge clk) disable iff (rst)
        (en && !tick) |=> $stable(tx_out));

endmodule

// File: tb/tsp_encoder_bench.sv
module tsp_encoder_bench;
    localparam int CLK_PERIOD = 10;
    localparam int NA_M = 10, ND_M = 8, NSYM_M = 18;
    localparam int NA_N = 12, NSYM_N = 12;
    localparam int WORD_M = NSYM_M * 8 + 16;   // 160 ticks
    localparam int WORD_N = NSYM_N * 8 + 16;   // 112 ticks

    logic clk = 1'b0;
    logic rst, tick, en;
    logic [2*NA_M-1:0] addr_m;
    logic [ND_M-1:0]   data_m;
    logic [2*NA_N-1:0] addr_n;
    logic              tx_m, tx_n;
    logic [63:0]       lat_m, lat_n;
    int checks = 0, fails = 0, k = 0;
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    tsp_encoder u_tsp_encoder (
        .clk(clk), .rst(rst), .tick(tick), .en(en),
        .addr_sym(addr_m), .data_bits(data_m), .tx_out(tx_m)
    );

    // R11: address-only configuration
    tsp_encoder #(.N_ADDR(NA_N), .N_DATA(0)) u_tsp_encoder_nd (
        .clk(clk), .rst(rst), .tick(tick), .en(en),
        .addr_sym(addr_n), .data_bits(1'b0), .tx_out(tx_n)
    );

    function automatic logic exp_level(int pos, int nsym, logic [63:0] codes);
        int sym, sb;
        logic sec, lng;
        logic [1:0] c;
        if (pos >= nsym * 8) return 1'b0;
        sym = pos / 8;
        sec = ((pos / 4) % 2) == 1;
        sb  = pos % 4;
        c   = codes[2*sym +: 2];
        if (c == 2'b00) lng = 1'b1;
        else if (c == 2'b01) lng = 1'b0;
        else lng = !sec;
        return sb < (lng ? 3 : 1);
    endfunction

    function automatic string tag(int pos, int nsym, int naddr, logic [63:0] codes);
        int sym;
        if (pos >= nsym * 8) return "R6 gap";
        sym = pos / 8;
        if (sym >= naddr) return "R1 R5 data";
        case (codes[2*sym +: 2])
            2'b00:   return "R1 R2 zero";
            2'b01:   return "R1 R3 one";
            default: return "R1 R4 open";
        endcase
    endfunction

    task automatic check(input logic act, input logic exp, input string req);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: tx=%b expected %b (k=%0d)", req, act, exp, k);
        end
    endtask

    function automatic logic [63:0] pack_m();
        logic [63:0] v = '0;
        for (int i = 0; i < NA_M; i++) v[2*i +: 2] = addr_m[2*i +: 2];
        for (int j = 0; j < ND_M; j++) v[2*(NA_M+j) +: 2] = {1'b0, data_m[j]};
        return v;
    endfunction

    function automatic logic [63:0] pack_n();
        logic [63:0] v = '0;
        for (int i = 0; i < NA_N; i++) v[2*i +: 2] = addr_n[2*i +: 2];
        return v;
    endfunction

    task automatic set_main(input int w);
        for (int i = 0; i < NA_M; i++)
            addr_m[2*i +: 2] = (w < 4) ? 2'(w) : 2'((i * 7 + w) % 4);
        data_m = (w == 0) ? 8'h00 : (w == 1) ? 8'hFF : (8'h5A ^ 8'(w * 29));
    endtask

    task automatic set_nd(input int w);
        for (int i = 0; i < NA_N; i++) addr_n[2*i +: 2] = 2'((i + w) % 4);
    endtask

    // One tick: the level after it is position k of the word; sampled
    // after the edge, then again one tick-less clock later (R9).
    task automatic do_tick();
        int pm = k % WORD_M;
        int pn = k % WORD_N;
        logic em, en_;
        if (pm == 0) lat_m = pack_m();   // R8: capture on word-start tick
        if (pn == 0) lat_n = pack_n();
        em  = exp_level(pm, NSYM_M, lat_m);
        en_ = exp_level(pn, NSYM_N, lat_n);
        tick = 1'b1;
        @(posedge clk); @(negedge clk);
        tick = 1'b0;
        check(tx_m, em, tag(pm, NSYM_M, NA_M, lat_m));
        check(tx_n, en_, {"R11 ", tag(pn, NSYM_N, NA_N, lat_n)});
        @(posedge clk); @(negedge clk);
        check(tx_m, em, "R9 hold");
        check(tx_n, en_, "R9 hold");
        k++;
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    end

    initial begin
        int w = 0, wn = 0;
        rst = 1'b1; tick = 1'b0; en = 1'b0;
        set_main(0); set_nd(0);
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        check(tx_m, 1'b0, "R10 reset");
        check(tx_n, 1'b0, "R10 reset");

        // R7: ticks with en low do nothing
        for (int i = 0; i < 3; i++) begin
            tick = 1'b1; @(posedge clk); @(negedge clk); tick = 1'b0;
            check(tx_m, 1'b0, "R7 disabled tick");
        end

        en = 1'b1;
        k = 0;
        for (int t = 0; t < 6 * WORD_M; t++) begin
            // R8: inputs move mid-word; the bench model keeps the captured copy
            if (k % WORD_M == 57) begin w++; set_main(w); end
            if (k % WORD_N == 30) begin wn++; set_nd(wn); end
            do_tick();
        end

        // R7: drop en mid-word, line low at once
        repeat (45) do_tick();
        en = 1'b0;
        @(posedge clk); @(negedge clk);
        check(tx_m, 1'b0, "R7 disable");
        check(tx_n, 1'b0, "R7 disable");
        for (int i = 0; i < 4; i++) begin
            tick = 1'b1; @(posedge clk); @(negedge clk); tick = 1'b0;
            check(tx_m, 1'b0, "R7 disabled tick");
            check(tx_n, 1'b0, "R7 disabled tick");
        end

        // R7: restart from the first pulse with fresh inputs
        set_main(9); set_nd(5);
        en = 1'b1;
        k = 0;
        for (int t = 0; t < WORD_M + 40; t++) begin
            if (k % WORD_M == 100) set_main(10);
            do_tick();
        end

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end
endmodule